// File: doc/BRIEF.md
# Encoder Host-Port Bring-Up Sequencer

This block is the host side of a slave media-encoder chip that sits behind a 16-bit, non-multiplexed, Intel-style write bus with one chip select. The chip's 128 internal registers are not mapped directly. Each access first writes a register number to an index port and then writes a value to a data port. After a start pulse, the sequencer runs a fixed power-up script. The script enables the chip's ready interrupt, programs its DSP clock and soft-resets it twice. Between the two resets it hands control to an external video-decoder setup through a request/acknowledge pair.

Once the chip is up, the block streams a firmware image from a byte source into the chip in chunks. Each chunk is opened by a start command and ends at an end-of-data interrupt. The block keeps loading chunks until the source marks the last byte. Every interrupt wait has a cycle timeout that parks the block in an error state. The write strobe's setup, low time and hold are set by parameters so that accesses stay in step with the slave's internal clock.

Top module: `enc_bringup_seq`

## Requirements
- R1: A register write is two bus writes. The first goes to the index port (`port_sel_o`=0) and carries the register number in bits 6:0 of `bus_data_o`. The second goes to the data port (`port_sel_o`=1) and carries the value in bits 7:0. All bits above these are zero.
- R2: On every bus write, `cs_n_o` is low for SETUP_CYC+PULSE_CYC+HOLD_CYC cycles. Within that window, `wr_n_o` goes low after SETUP_CYC cycles and stays low for exactly PULSE_CYC cycles. `port_sel_o` and `bus_data_o` hold steady while `cs_n_o` is low.
- R3: After `start_i`, the register writes come in this order: 0x40 to 0x0C, then 0x0A to 0x1E, then 0x55 to 0x0B, then 0x40 to 0x0C. An interrupt wait and clear separates the first and second of these.
- R4: Each wait lasts until its interrupt line is high. The block then clears that interrupt by writing its bit to status register 0x0D: 0x40 for ready, 0x20 for end-of-data.
- R5: After the ready that follows the first soft reset has been cleared (12 bus writes from start), `dec_init_req_o` goes high. It stays high until `dec_init_ack_i` arrives. The block then writes 0x55 to 0x0B and 0x40 to 0x0C, and waits for and clears ready.
- R6: A chunk proceeds as follows. Write 0x04 to 0x08. Wait for ready and clear it. Write index 0x01 once. Write one data-port word per firmware byte, in source order. Wait for end-of-data and clear it.
- R7: A chunk holds CHUNK_BYTES bytes, except that a chunk ends early at the byte flagged by `fw_last_i`. Chunks repeat until that byte has been sent. `done_o` rises only after the last end-of-data clear, and from then on the bus stays idle.
- R8: If an interrupt stays low for IRQ_TIMEOUT cycles of a wait, `error_o` rises. No further bus writes happen, and `done_o` stays low.
- R9: `fw_ready_o` is high only while `fw_valid_i` is high. Each byte is taken exactly once. While no byte is offered, the bus stalls.
- R10: After reset, `cs_n_o` and `wr_n_o` are high and `done_o`, `error_o`, `dec_init_req_o` and `fw_ready_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Starts the bring-up script (idle, done or error) |
| irq_ready_i | input | 1 | Slave ready interrupt line, active high |
| irq_eod_i | input | 1 | Slave end-of-data interrupt line, active high |
| fw_valid_i | input | 1 | Firmware byte offered |
| fw_data_i | input | 8 | Firmware byte |
| fw_last_i | input | 1 | Offered byte is the last of the image |
| fw_ready_o | output | 1 | Offered byte taken this cycle |
| cs_n_o | output | 1 | Slave chip select, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| port_sel_o | output | 1 | 0 = index port, 1 = data port |
| bus_data_o | output | 16 | Write data |
| dec_init_req_o | output | 1 | Request to run external decoder setup |
| dec_init_ack_i | input | 1 | Decoder setup finished |
| done_o | output | 1 | Firmware fully loaded |
| error_o | output | 1 | An interrupt wait timed out |

## Verification
The bench feeds an image of 300 bytes, whose final chunk is short, and then an image of exactly one full chunk. A design that mixed up the chunk-full and last-byte exits would either send an empty extra chunk or run past the image, and the write scoreboard would catch either. The byte source drops its valid flag every few cycles, so a design that wrote while no byte was offered would put stale data on the bus. At every interrupt clear the bench checks that the line was really high, which exposes a design that runs through its waits without stalling. A run in which ready never comes checks that the error flag rises near the timeout and not early, and that the bus then stays quiet.

// File: rtl/enc_bringup_pkg.sv
package enc_bringup_pkg;

  typedef enum logic [2:0] {
    OP_WR, OP_WAIT_RDY, OP_WAIT_EOD, OP_DEC, OP_STREAM, OP_LOOP
  } op_e;

  typedef enum logic [1:0] {SQ_IDLE, SQ_RUN, SQ_DONE, SQ_ERR} sq_e;
  typedef enum logic [1:0] {BW_IDLE, BW_SETUP, BW_PULSE, BW_HOLD} bw_e;

  typedef struct packed {
    op_e        kind;
    logic [6:0] idx;
    logic [7:0] val;
  } step_t;

  localparam int unsigned STEP_W     = 5;
  localparam int unsigned CHUNK_STEP = 13;

  localparam logic [6:0] REG_IRQ_EN   = 7'h0C;
  localparam logic [6:0] REG_IRQ_STAT = 7'h0D;
  localparam logic [6:0] REG_DSP_CLK  = 7'h1E;
  localparam logic [6:0] REG_SOFT_RST = 7'h0B;
  localparam logic [6:0] REG_CMD      = 7'h08;
  localparam logic [6:0] REG_FW_DATA  = 7'h01;
  localparam logic [7:0] IRQ_RDY      = 8'h40;
  localparam logic [7:0] IRQ_EOD      = 8'h20;

  // Bring-up script; steps CHUNK_STEP..19 form the chunk loop.
  function automatic step_t script(input logic [STEP_W-1:0] s);
    step_t r;
    r = '{OP_LOOP, 7'h00, 8'h00};
    case (s)
      5'd0:  r = '{OP_WR,       REG_IRQ_EN,   IRQ_RDY};
      5'd1:  r = '{OP_WAIT_RDY, 7'h00,        8'h00};
      5'd2:  r = '{OP_WR,       REG_IRQ_STAT, IRQ_RDY};
      5'd3:  r = '{OP_WR,       REG_DSP_CLK,  8'h0A};
      5'd4:  r = '{OP_WR,       REG_SOFT_RST, 8'h55};
      5'd5:  r = '{OP_WR,       REG_IRQ_EN,   IRQ_RDY};
      5'd6:  r = '{OP_WAIT_RDY, 7'h00,        8'h00};
      5'd7:  r = '{OP_WR,       REG_IRQ_STAT, IRQ_RDY};
      5'd8:  r = '{OP_DEC,      7'h00,        8'h00};
      5'd9:  r = '{OP_WR,       REG_SOFT_RST, 8'h55};
      5'd10: r = '{OP_WR,       REG_IRQ_EN,   IRQ_RDY};
      5'd11: r = '{OP_WAIT_RDY, 7'h00,        8'h00};
      5'd12: r = '{OP_WR,       REG_IRQ_STAT, IRQ_RDY};
      5'd13: r = '{OP_WR,       REG_CMD,      8'h04};
      5'd14: r = '{OP_WAIT_RDY, 7'h00,        8'h00};
      5'd15: r = '{OP_WR,       REG_IRQ_STAT, IRQ_RDY};
      5'd16: r = '{OP_STREAM,   REG_FW_DATA,  8'h00};
      5'd17: r = '{OP_WAIT_EOD, 7'h00,        8'h00};
      5'd18: r = '{OP_WR,       REG_IRQ_STAT, IRQ_EOD};
      default: r = '{OP_LOOP,   7'h00,        8'h00};
    endcase
    return r;
  endfunction

  function automatic logic [15:0] index_word(input logic [6:0] idx);
    return {9'd0, idx};
  endfunction

  function automatic logic [15:0] value_word(input logic [7:0] v);
    return {8'd0, v};
  endfunction

endpackage

// File: rtl/enc_bus_wr.sv
module enc_bus_wr
  import enc_bringup_pkg::*;
#(
  parameter int unsigned SETUP_CYC = 2,
  parameter int unsigned PULSE_CYC = 3,
  parameter int unsigned HOLD_CYC  = 1,
  parameter int unsigned DW        = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go_i,
  input  logic          sel_i,
  input  logic [DW-1:0] word_i,
  output logic          cs_n_o,
  output logic          wr_n_o,
  output logic          sel_o,
  output logic [DW-1:0] word_o,
  output logic          idle_o,
  output logic          done_o
);
  localparam int unsigned TMAX = (SETUP_CYC > PULSE_CYC) ?
    ((SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC) :
    ((PULSE_CYC > HOLD_CYC) ? PULSE_CYC : HOLD_CYC);
  localparam int unsigned CW = $clog2(TMAX + 1);

  bw_e           st_q;
  logic [CW-1:0] cnt_q;
  logic          sel_q;
  logic [DW-1:0] word_q;
  logic          last_tick;

  assign last_tick = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= BW_IDLE;
      cnt_q  <= '0;
      sel_q  <= 1'b0;
      word_q <= '0;
    end else begin
      unique case (st_q)
        BW_IDLE: if (go_i) begin
          st_q   <= BW_SETUP;
          cnt_q  <= CW'(SETUP_CYC - 1);
          sel_q  <= sel_i;
          word_q <= word_i;
        end
        BW_SETUP: if (last_tick) begin
          st_q  <= BW_PULSE;
          cnt_q <= CW'(PULSE_CYC - 1);
        end else cnt_q <= cnt_q - 1'b1;
        BW_PULSE: if (last_tick) begin
          st_q  <= BW_HOLD;
          cnt_q <= CW'(HOLD_CYC - 1);
        end else cnt_q <= cnt_q - 1'b1;
        BW_HOLD: if (last_tick) st_q <= BW_IDLE;
                 else cnt_q <= cnt_q - 1'b1;
        default: st_q <= BW_IDLE;
      endcase
    end
  end

  assign cs_n_o = (st_q == BW_IDLE);
  assign wr_n_o = (st_q != BW_PULSE);
  assign sel_o  = sel_q;
  assign word_o = word_q;
  assign idle_o = (st_q == BW_IDLE);
  assign done_o = (st_q == BW_HOLD) && last_tick;

endmodule

// File: rtl/enc_irq_watch.sv
module enc_irq_watch #(
  parameter int unsigned IRQ_TIMEOUT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic line_i,
  output logic hit_o,
  output logic expire_o
);
  localparam int unsigned TW = $clog2(IRQ_TIMEOUT + 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !en_i) cnt_q <= '0;
    else if (!line_i)    cnt_q <= cnt_q + 1'b1;
  end

  assign hit_o    = en_i && line_i;
  assign expire_o = en_i && !line_i && (cnt_q == TW'(IRQ_TIMEOUT - 1));

endmodule

// File: rtl/enc_bringup_seq.sv
module enc_bringup_seq
  import enc_bringup_pkg::*;
#(
  parameter int unsigned SETUP_CYC   = 2,
  parameter int unsigned PULSE_CYC   = 3,
  parameter int unsigned HOLD_CYC    = 1,
  parameter int unsigned IRQ_TIMEOUT = 100000,
  parameter int unsigned CHUNK_BYTES = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        irq_ready_i,
  input  logic        irq_eod_i,
  input  logic        fw_valid_i,
  input  logic [7:0]  fw_data_i,
  input  logic        fw_last_i,
  output logic        fw_ready_o,
  output logic        cs_n_o,
  output logic        wr_n_o,
  output logic        port_sel_o,
  output logic [15:0] bus_data_o,
  output logic        dec_init_req_o,
  input  logic        dec_init_ack_i,
  output logic        done_o,
  output logic        error_o
);
  localparam int unsigned BW = (CHUNK_BYTES > 1) ? $clog2(CHUNK_BYTES) : 1;

  sq_e               sq_q;
  logic [STEP_W-1:0] step_q;
  logic              half_q;
  logic [BW-1:0]     bcnt_q;
  logic              last_q;
  logic              img_end_q;
  step_t             cur;

  // Named internal events, also used by the checker.
  logic        run, uses_bus, need_byte, bus_go, bus_idle, bus_done;
  logic        watch_en, watch_line, irq_hit, irq_expire, chunk_full;
  logic [15:0] bus_word;

  assign cur        = script(step_q);
  assign run        = (sq_q == SQ_RUN);
  assign uses_bus   = run && (cur.kind == OP_WR || cur.kind == OP_STREAM);
  assign need_byte  = (cur.kind == OP_STREAM) && half_q;
  assign bus_go     = uses_bus && bus_idle && (!need_byte || fw_valid_i);
  assign fw_ready_o = bus_go && need_byte;
  assign bus_word   = !half_q   ? index_word(cur.idx) :
                      need_byte ? value_word(fw_data_i) : value_word(cur.val);
  assign chunk_full = (bcnt_q == BW'(CHUNK_BYTES - 1));
  assign watch_en   = run && (cur.kind == OP_WAIT_RDY || cur.kind == OP_WAIT_EOD);
  assign watch_line = (cur.kind == OP_WAIT_RDY) ? irq_ready_i : irq_eod_i;

  enc_bus_wr #(
    .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC), .HOLD_CYC(HOLD_CYC), .DW(16)
  ) i_bus (
    .clk(clk), .rst_n(rst_n), .go_i(bus_go), .sel_i(half_q), .word_i(bus_word),
    .cs_n_o(cs_n_o), .wr_n_o(wr_n_o), .sel_o(port_sel_o), .word_o(bus_data_o),
    .idle_o(bus_idle), .done_o(bus_done)
  );

  enc_irq_watch #(.IRQ_TIMEOUT(IRQ_TIMEOUT)) i_watch (
    .clk(clk), .rst_n(rst_n), .en_i(watch_en), .line_i(watch_line),
    .hit_o(irq_hit), .expire_o(irq_expire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sq_q      <= SQ_IDLE;
      step_q    <= '0;
      half_q    <= 1'b0;
      bcnt_q    <= '0;
      last_q    <= 1'b0;
      img_end_q <= 1'b0;
    end else if (!run) begin
      if (start_i) begin
        sq_q      <= SQ_RUN;
        step_q    <= '0;
        half_q    <= 1'b0;
        bcnt_q    <= '0;
        img_end_q <= 1'b0;
      end
    end else begin
      unique case (cur.kind)
        OP_WR: if (bus_done) begin
          half_q <= ~half_q;
          if (half_q) step_q <= step_q + 1'b1;
        end
        OP_STREAM: begin
          if (fw_ready_o) last_q <= fw_last_i;
          if (bus_done) begin
            if (!half_q) half_q <= 1'b1;
            else if (last_q || chunk_full) begin
              half_q    <= 1'b0;
              bcnt_q    <= '0;
              img_end_q <= last_q;
              step_q    <= step_q + 1'b1;
            end else bcnt_q <= bcnt_q + 1'b1;
          end
        end
        OP_WAIT_RDY, OP_WAIT_EOD: begin
          if (irq_hit)         step_q <= step_q + 1'b1;
          else if (irq_expire) sq_q   <= SQ_ERR;
        end
        OP_DEC: if (dec_init_ack_i) step_q <= step_q + 1'b1;
        OP_LOOP: begin
          if (img_end_q) sq_q   <= SQ_DONE;
          else           step_q <= STEP_W'(CHUNK_STEP);
        end
        default: sq_q <= SQ_ERR;
      endcase
    end
  end

  assign dec_init_req_o = run && (cur.kind == OP_DEC);
  assign done_o         = (sq_q == SQ_DONE);
  assign error_o        = (sq_q == SQ_ERR);

endmodule

// File: rtl/enc_bringup_chk.sv
module enc_bringup_chk #(
  parameter int unsigned PULSE_CYC = 3
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cs_n,
  input logic        wr_n,
  input logic        port_sel,
  input logic [15:0] bus_data,
  input logic        done,
  input logic        error,
  input logic        dec_req,
  input logic        dec_ack,
  input logic        fw_valid,
  input logic        fw_ready,
  input logic        bus_done
);
  localparam int unsigned PW = $clog2(PULSE_CYC + 2);
  logic [PW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || wr_n) low_cnt <= '0;
    else                low_cnt <= low_cnt + 1'b1;
  end

  p_strobe_in_select_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> !cs_n);
  p_bus_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n)) |-> ($stable(bus_data) && $stable(port_sel)));
  p_pulse_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |-> (low_cnt == PW'(PULSE_CYC)));
  p_write_ends_in_select_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_done |-> (!cs_n && wr_n));
  p_dec_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_req && !dec_ack) |=> dec_req);
  p_done_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_n && !error));
  p_error_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> (cs_n && !dec_req));
  p_ready_needs_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fw_ready |-> fw_valid);

endmodule

bind enc_bringup_seq enc_bringup_chk #(.PULSE_CYC(PULSE_CYC)) i_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n_o), .wr_n(wr_n_o), .port_sel(port_sel_o),
  .bus_data(bus_data_o), .done(done_o), .error(error_o), .dec_req(dec_init_req_o),
  .dec_ack(dec_init_ack_i), .fw_valid(fw_valid_i), .fw_ready(fw_ready_o),
  .bus_done(bus_done)
);

// File: tb/test_enc_bringup_seq.sv
module test_enc_bringup_seq;
  localparam int S = 2, P = 3, H = 1, TMO = 300, CHUNK = 256;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0, start = 1'b0;
  logic        irq_ready = 1'b0, irq_eod = 1'b0;
  logic        fw_valid = 1'b0, fw_last = 1'b0, fw_ready;
  logic [7:0]  fw_data = 8'h00;
  logic        cs_n, wr_n, port_sel, dec_req, done, error;
  logic        dec_ack = 1'b0;
  logic [15:0] bus_data;

  enc_bringup_seq #(.SETUP_CYC(S), .PULSE_CYC(P), .HOLD_CYC(H),
                    .IRQ_TIMEOUT(TMO), .CHUNK_BYTES(CHUNK)) i_enc_bringup_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start), .irq_ready_i(irq_ready),
    .irq_eod_i(irq_eod), .fw_valid_i(fw_valid), .fw_data_i(fw_data),
    .fw_last_i(fw_last), .fw_ready_o(fw_ready), .cs_n_o(cs_n), .wr_n_o(wr_n),
    .port_sel_o(port_sel), .bus_data_o(bus_data), .dec_init_req_o(dec_req),
    .dec_init_ack_i(dec_ack), .done_o(done), .error_o(error)
  );

  int checks = 0, errors = 0, cyc = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_sim();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  function automatic logic [7:0] img_byte(input int i);
    return 8'(i * 7 + 3);
  endfunction

  // Scoreboard of expected bus writes: {port_sel, data}.
  logic [16:0] exp_q[$];

  task automatic push_w(input bit a, input logic [15:0] d);
    exp_q.push_back({a, d});
  endtask

  task automatic push_reg(input logic [7:0] idx, input logic [7:0] val);
    push_w(1'b0, {8'h00, idx});
    push_w(1'b1, {8'h00, val});
  endtask

  task automatic build_expect(input int len, input bit stall_rdy);
    int off;
    exp_q.delete();
    push_reg(8'h0C, 8'h40);
    if (stall_rdy) return;
    push_reg(8'h0D, 8'h40);
    push_reg(8'h1E, 8'h0A);
    push_reg(8'h0B, 8'h55);
    push_reg(8'h0C, 8'h40);
    push_reg(8'h0D, 8'h40);
    push_reg(8'h0B, 8'h55);
    push_reg(8'h0C, 8'h40);
    push_reg(8'h0D, 8'h40);
    off = 0;
    while (off < len) begin
      int n;
      n = (len - off > CHUNK) ? CHUNK : len - off;
      push_reg(8'h08, 8'h04);
      push_reg(8'h0D, 8'h40);
      push_w(1'b0, 16'h0001);
      for (int i = 0; i < n; i++) push_w(1'b1, {8'h00, img_byte(off + i)});
      push_reg(8'h0D, 8'h20);
      off += n;
    end
  endtask

  // Slave and source model state.
  int   img_len = 0, run_id = 0, seen_id = 0;
  bit   stall = 1'b0, fw_take = 1'b0, dec_seen = 1'b0;
  int   fw_idx = 0, n_writes = 0, chunk_off = 0, chunk_bytes = 0;
  int   rdy_cd = 0, eod_cd = 0, dec_cd = 0;
  int   cs_cnt = 0, wr_cnt = 0, su_cnt = 0;
  logic [6:0] last_idx = 7'h00;
  logic prev_wr = 1'b1, prev_cs = 1'b1;

  always @(posedge clk) begin
    cyc++;
    fw_take <= fw_valid && fw_ready;
    if (fw_ready && !fw_valid) chk(1'b0, "R9", "ready without valid", 1, 0);
    if (cyc > 150000) begin
      chk(1'b0, "WDOG", "watchdog expired", cyc, 150000);
      finish_sim();
    end
  end

  // Monitor: pops the scoreboard on each completed write; also the slave model.
  always @(negedge clk) begin
    if (run_id != seen_id) begin
      seen_id = run_id;
      fw_idx = 0; n_writes = 0; chunk_off = 0; chunk_bytes = 0;
      rdy_cd = 0; eod_cd = 0; dec_cd = 0; dec_seen = 1'b0;
      irq_ready = 1'b0; irq_eod = 1'b0;
    end else if (fw_take) fw_idx++;

    if (!cs_n) cs_cnt++;
    if (!wr_n) wr_cnt++;
    if (!cs_n && wr_n && wr_cnt == 0) su_cnt++;

    if (!prev_wr && wr_n) begin
      logic [16:0] got;
      got = {port_sel, bus_data};
      n_writes++;
      if (exp_q.size() == 0) chk(1'b0, "R3", "unexpected write", got, 0);
      else begin
        logic [16:0] want;
        want = exp_q.pop_front();
        chk(got == want, "R1/R3/R6", "write sequence", got, want);
      end
      if (!port_sel) last_idx = bus_data[6:0];
      else begin
        case (last_idx)
          7'h0C: if (bus_data[7:0] == 8'h40 && !stall) rdy_cd = 4;
          7'h08: if (bus_data[7:0] == 8'h04) rdy_cd = 4;
          7'h0D: begin
            if (bus_data[6]) begin
              chk(irq_ready, "R4", "ready clear while line low", 0, 1);
              irq_ready = 1'b0;
            end
            if (bus_data[5]) begin
              chk(irq_eod, "R6", "eod clear while line low", 0, 1);
              irq_eod = 1'b0;
              chunk_off += chunk_bytes;
              chunk_bytes = 0;
            end
          end
          7'h01: begin
            chunk_bytes++;
            if (chunk_bytes == ((img_len - chunk_off > CHUNK) ? CHUNK : img_len - chunk_off))
              eod_cd = 4;
          end
          default: ;
        endcase
      end
    end

    if (!prev_cs && cs_n) begin
      chk(cs_cnt == S + P + H, "R2", "select width", cs_cnt, S + P + H);
      chk(wr_cnt == P, "R2", "strobe width", wr_cnt, P);
      chk(su_cnt == S, "R2", "setup width", su_cnt, S);
      cs_cnt = 0; wr_cnt = 0; su_cnt = 0;
    end
    prev_wr = wr_n;
    prev_cs = cs_n;

    if (rdy_cd == 1) irq_ready = 1'b1;
    if (rdy_cd > 0) rdy_cd--;
    if (eod_cd == 1) irq_eod = 1'b1;
    if (eod_cd > 0) eod_cd--;

    dec_ack = 1'b0;
    if (dec_req && !dec_seen) begin
      dec_seen = 1'b1;
      chk(n_writes == 12, "R5", "writes before decoder request", n_writes, 12);
      dec_cd = 3;
    end
    if (dec_cd == 1) dec_ack = 1'b1;
    if (dec_cd > 0) dec_cd--;

    fw_valid = (fw_idx < img_len) && (cyc % 5 != 2);
    fw_data  = img_byte(fw_idx);
    fw_last  = (fw_idx == img_len - 1);
  end

  task automatic run_image(input int len);
    img_len = len;
    stall = 1'b0;
    build_expect(len, 1'b0);
    run_id++;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && !error) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(done == 1'b1, "R7", "done after last chunk", done, 1);
    chk(error == 1'b0, "R8", "no error on good run", error, 0);
    chk(exp_q.size() == 0, "R7", "writes left in scoreboard", exp_q.size(), 0);
    chk(fw_idx == len, "R9", "bytes taken", fw_idx, len);
    chk(cs_n == 1'b1, "R7", "bus idle after done", cs_n, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n && wr_n, "R10", "strobes idle after reset", {cs_n, wr_n}, 2'b11);
    chk(!done && !error, "R10", "flags low after reset", {done, error}, 0);
    chk(!dec_req && !fw_ready, "R10", "request/ready low after reset",
        {dec_req, fw_ready}, 0);

    run_image(300);   // full chunk plus short final chunk
    run_image(256);   // image exactly one chunk

    // Ready never arrives: timeout path.
    img_len = 0;
    stall = 1'b1;
    build_expect(0, 1'b1);
    run_id++;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (n_writes < 2) @(negedge clk);
    repeat (TMO - 5) @(negedge clk);
    chk(error == 1'b0, "R8", "error before timeout", error, 0);
    repeat (15) @(negedge clk);
    chk(error == 1'b1, "R8", "error after timeout", error, 1);
    repeat (50) @(negedge clk);
    chk(n_writes == 2, "R8", "writes after error", n_writes, 2);
    chk(cs_n == 1'b1 && done == 1'b0, "R8", "bus quiet, no done", {cs_n, done}, 2'b10);
    chk(exp_q.size() == 0, "R3", "first enable written", exp_q.size(), 0);

    finish_sim();
  end

endmodule